// File: doc/BRIEF.md
# 32-Pin GPIO Port with Per-Pin Interrupt Triggers

This block is a general-purpose I/O port. A plain register bus (valid, write, address, write data, read data) reaches a set of 32-bit registers. These registers drive the pads' output values and output enables, show the synchronized pad levels, and set an interrupt trigger for each pin. Every pad input passes through a two-flop synchronizer. A further flop holds the previous synchronized value, so edges can be found. Each pin's trigger can be a level (low or high) or an edge (rising or falling), chosen by a 2-bit code. A per-pin any-edge bit overrides that code.

Trigger events set sticky status bits, which software clears by writing ones to them. A status bit is forwarded only when its mask bit is set. The port has two interrupt outputs: one for the lower half of the pins and one for the upper half. Software reaches the port through the bus: it programs triggers, polls or takes the interrupt, and clears the status bits it has serviced.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero, all output enables are low, and both interrupt outputs are low.
- R2: The output value register (word 0x00) drives `padOut` and reads back the value last written, whatever the pads show. The direction register (word 0x04) drives `padOe`: 1 makes a pin an output, 0 makes it an input.
- R3: Word 0x08 returns the pad levels through a two-flop synchronizer. A pad change applied before one rising edge is visible after the second rising edge. Writes to this word are ignored.
- R4: Pin n takes its 2-bit trigger field from word 0x0C when n < 16 and from word 0x10 when n >= 16, at bits [2*(n mod 16)+1 : 2*(n mod 16)]. Both words read back as written.
- R5: Trigger codes are 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. The matching status bit is set at the third rising edge after the pad change (two synchronizer flops, then the status flop).
- R6: When a pin's bit in the any-edge word (0x1C) is 1, that pin sets its status on both rising and falling edges, and its 2-bit field has no effect.
- R7: The status word (0x18) is sticky. Writing a 1 to a bit clears only that bit; bits written 0 keep their value.
- R8: A level trigger sets its status on every cycle the level holds. If a clear and a set reach the same bit in the same cycle, the set wins.
- R9: `irqLow` is the OR of status AND mask over pins 0..15, and `irqHigh` is the same over pins 16..31. The mask word is 0x14, where 1 enables a pin.
- R10: Only word-aligned addresses in 0x00..0x1C decode. Any other address neither writes a register nor returns data (it reads as zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte address |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, combinational, same cycle |
| padIn | input | NUM_PINS (32) | Pad input levels, asynchronous |
| padOut | output | NUM_PINS (32) | Pad output values |
| padOe | output | NUM_PINS (32) | Pad output enables |
| irqLow | output | 1 | Interrupt request for the lower pin half |
| irqHigh | output | 1 | Interrupt request for the upper pin half |

## Verification
The bench builds the port with its default parameters: 32 pins, a 32-bit data path and a 5-bit address. This keeps the split between the two trigger-field words and the two interrupt outputs at pin 15/16 in reach. With this size the bench sweeps every pin through all five trigger kinds: the four codes plus the any-edge override. Each expected status word, field layout and interrupt half is computed from the pin index. Separate directed passes cover the exact synchronizer and status latency, selective clearing, and misaligned addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index taken from address bits [4:2]
  localparam logic [2:0] IDX_DATA  = 3'd0;
  localparam logic [2:0] IDX_DIR   = 3'd1;
  localparam logic [2:0] IDX_PADS  = 3'd2;
  localparam logic [2:0] IDX_CFGLO = 3'd3;
  localparam logic [2:0] IDX_CFGHI = 3'd4;
  localparam logic [2:0] IDX_MASK  = 3'd5;
  localparam logic [2:0] IDX_STAT  = 3'd6;
  localparam logic [2:0] IDX_EDGE  = 3'd7;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic       wrData;
    logic       wrDir;
    logic       wrCfgLo;
    logic       wrCfgHi;
    logic       wrMask;
    logic       wrStat;
    logic       wrEdge;
    logic       rdEn;
    logic [2:0] rdSel;
  } gpio_strobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gpio_strobe_t      stb
);

  logic       hit;
  logic       wrHit;
  logic [2:0] wordIdx;

  // Word aligned, and nothing set above the 8-word window
  assign hit     = busValid && (busAddr[1:0] == 2'b00) && ((busAddr >> 5) == '0);
  assign wrHit   = hit && busWrite;
  assign wordIdx = busAddr[4:2];

  always_comb begin
    stb         = '0;
    stb.rdEn    = hit && !busWrite;
    stb.rdSel   = wordIdx;
    stb.wrData  = wrHit && (wordIdx == IDX_DATA);
    stb.wrDir   = wrHit && (wordIdx == IDX_DIR);
    stb.wrCfgLo = wrHit && (wordIdx == IDX_CFGLO);
    stb.wrCfgHi = wrHit && (wordIdx == IDX_CFGHI);
    stb.wrMask  = wrHit && (wordIdx == IDX_MASK);
    stb.wrStat  = wrHit && (wordIdx == IDX_STAT);
    stb.wrEdge  = wrHit && (wordIdx == IDX_EDGE);
  end

endmodule

// File: rtl/gpio_irq_dpath.sv
module gpio_irq_dpath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpio_strobe_t        stb,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padSyncd,
  output logic [NUM_PINS-1:0] statVec,
  output logic [NUM_PINS-1:0] maskVec,
  output logic                irqLow,
  output logic                irqHigh
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] dataQ, dirQ, maskQ, statQ, edgeQ;
  logic [DATA_W-1:0]   cfgLoQ, cfgHiQ;
  logic [NUM_PINS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncQ, prevQ;
  logic [NUM_PINS-1:0] statSet, statClr;
  logic [DATA_W-1:0]   rdMux;

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      maskQ  <= '0;
      edgeQ  <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
    end else begin
      if (stb.wrData)  dataQ  <= busWdata[NUM_PINS-1:0];
      if (stb.wrDir)   dirQ   <= busWdata[NUM_PINS-1:0];
      if (stb.wrMask)  maskQ  <= busWdata[NUM_PINS-1:0];
      if (stb.wrEdge)  edgeQ  <= busWdata[NUM_PINS-1:0];
      if (stb.wrCfgLo) cfgLoQ <= busWdata;
      if (stb.wrCfgHi) cfgHiQ <= busWdata;
    end
  end

  // ---------------- pad synchronizer and history ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
      prevQ <= '0;
    end else begin
      syncPipe[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      prevQ <= syncPipe[SYNC_STAGES-1];
    end
  end

  assign syncQ = syncPipe[SYNC_STAGES-1];

  // ---------------- per-pin trigger detection ----------------
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] fieldQ;
    logic       hit;

    if (i < HALF) begin : g_lo
      assign fieldQ = cfgLoQ[2*i +: 2];
    end else begin : g_hi
      assign fieldQ = cfgHiQ[2*(i-HALF) +: 2];
    end

    always_comb begin
      if (edgeQ[i]) begin
        hit = syncQ[i] ^ prevQ[i];
      end else begin
        unique case (trig_e'(fieldQ))
          TRIG_LOW:  hit = !syncQ[i];
          TRIG_HIGH: hit = syncQ[i];
          TRIG_RISE: hit = syncQ[i] && !prevQ[i];
          TRIG_FALL: hit = !syncQ[i] && prevQ[i];
          default:   hit = 1'b0;
        endcase
      end
    end

    assign statSet[i] = hit;
  end

  // ---------------- sticky status, set beats clear ----------------
  assign statClr = stb.wrStat ? busWdata[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~statClr) | statSet;
  end

  // ---------------- interrupt outputs ----------------
  assign irqLow  = |(statQ[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHigh = |(statQ[NUM_PINS-1:HALF] & maskQ[NUM_PINS-1:HALF]);

  // ---------------- read back ----------------
  always_comb begin
    unique case (stb.rdSel)
      IDX_DATA:  rdMux = DATA_W'(dataQ);
      IDX_DIR:   rdMux = DATA_W'(dirQ);
      IDX_PADS:  rdMux = DATA_W'(syncQ);
      IDX_CFGLO: rdMux = cfgLoQ;
      IDX_CFGHI: rdMux = cfgHiQ;
      IDX_MASK:  rdMux = DATA_W'(maskQ);
      IDX_STAT:  rdMux = DATA_W'(statQ);
      IDX_EDGE:  rdMux = DATA_W'(edgeQ);
      default:   rdMux = '0;
    endcase
  end

  assign busRdata = stb.rdEn ? rdMux : '0;

  assign padOut   = dataQ;
  assign padOe    = dirQ;
  assign padSyncd = syncQ;
  assign statVec  = statQ;
  assign maskVec  = maskQ;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh
);

  gpio_strobe_t        stb;
  logic [NUM_PINS-1:0] padSyncd;
  logic [NUM_PINS-1:0] statVec;
  logic [NUM_PINS-1:0] maskVec;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  gpio_irq_dpath #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (2)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .padSyncd (padSyncd),
    .statVec  (statVec),
    .maskVec  (maskVec),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh)
  );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                busValid,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padSyncd,
  input logic [NUM_PINS-1:0] statVec,
  input logic [NUM_PINS-1:0] maskVec,
  input logic                irqLow,
  input logic                irqHigh
);

  localparam int HALF = NUM_PINS / 2;

  logic [1:0]          upCnt;
  logic                wrAny;
  logic [NUM_PINS-1:0] clrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               upCnt <= '0;
    else if (upCnt != 2'd3)  upCnt <= upCnt + 2'd1;
  end

  assign wrAny   = busValid && busWrite;
  assign clrMask = (wrAny && busAddr == ADDR_W'(8'h18)) ? busWdata[NUM_PINS-1:0] : '0;

  // R2: output data and enables follow register writes
  p_data_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == ADDR_W'(8'h00)) |=> padOut == $past(busWdata[NUM_PINS-1:0]));

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == ADDR_W'(8'h04)) |=> padOe == $past(busWdata[NUM_PINS-1:0]));

  // R3: synchronized pad view lags the pads by two edges
  p_pad_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2) |-> padSyncd == $past(padIn, 2));

  // R7: pending bits not written with 1 stay pending
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statVec & $past(statVec & ~clrMask)) == $past(statVec & ~clrMask)));

  // R9: a fully masked half never requests
  p_irq_low_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec[HALF-1:0] == '0) |-> !irqLow);

  p_irq_high_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec[NUM_PINS-1:HALF] == '0) |-> !irqHigh);

  p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statVec == '0) |-> (!irqLow && !irqHigh));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .padSyncd (padSyncd),
  .statVec  (statVec),
  .maskVec  (maskVec),
  .irqLow   (irqLow),
  .irqHigh  (irqHigh)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;

  localparam int NP = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_DATA  = 5'h00;
  localparam logic [AW-1:0] A_DIR   = 5'h04;
  localparam logic [AW-1:0] A_PADS  = 5'h08;
  localparam logic [AW-1:0] A_CFGLO = 5'h0C;
  localparam logic [AW-1:0] A_CFGHI = 5'h10;
  localparam logic [AW-1:0] A_MASK  = 5'h14;
  localparam logic [AW-1:0] A_STAT  = 5'h18;
  localparam logic [AW-1:0] A_EDGE  = 5'h1C;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe;
  logic          irqLow, irqHigh;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #0.5;
    d = busRdata;
    busValid = 1'b0;
  endtask

  // Trigger words: every pin rising-edge except pin p which gets code c
  task automatic setCfg(input int p, input logic [1:0] c);
    logic [63:0] cfgAll;
    for (int f = 0; f < NP; f++) cfgAll[2*f +: 2] = 2'b10;
    cfgAll[2*p +: 2] = c;
    busWr(A_CFGLO, cfgAll[31:0]);
    busWr(A_CFGHI, cfgAll[63:32]);
  endtask

  initial begin
    logic [DW-1:0] rd;
    // ---------------- R1: reset state ----------------
    idle(3);
    for (int w = 0; w < 8; w++) begin
      busRd(AW'(w * 4), rd);
      check("R1 reg reads zero in reset", rd, '0);
    end
    check("R1 padOe in reset", padOe, '0);
    check("R1 irq in reset", {30'd0, irqHigh, irqLow}, '0);
    rstN = 1'b1;
    idle(1);
    busRd(A_MASK, rd);
    check("R1 mask zero after reset", rd, '0);
    check("R1 irq after reset", {30'd0, irqHigh, irqLow}, '0);

    // ---------------- R2: data and direction ----------------
    padIn = 32'h1234_5678;
    busWr(A_DIR, 32'hFFFF_0000);
    busWr(A_DATA, 32'hA5A5_5A5A);
    check("R2 padOe follows direction", padOe, 32'hFFFF_0000);
    check("R2 padOut follows data", padOut, 32'hA5A5_5A5A);
    idle(3);
    busRd(A_DATA, rd);
    check("R2 data reads written value not pads", rd, 32'hA5A5_5A5A);
    busRd(A_DIR, rd);
    check("R2 direction readback", rd, 32'hFFFF_0000);

    // ---------------- R3 / R10: pad view, write ignored ----------------
    busRd(A_PADS, rd);
    check("R3 pad view", rd, 32'h1234_5678);
    busWr(A_PADS, 32'hFFFF_FFFF);
    busRd(A_PADS, rd);
    check("R3 pad view write ignored", rd, 32'h1234_5678);

    // ---------------- R10: misaligned / unmapped ----------------
    busWr(5'h01, 32'hDEAD_BEEF);
    busRd(A_DATA, rd);
    check("R10 misaligned write ignored", rd, 32'hA5A5_5A5A);
    busRd(5'h02, rd);
    check("R10 misaligned read zero", rd, '0);

    // ---------------- R4: config readback ----------------
    busWr(A_CFGLO, 32'h0123_4567);
    busWr(A_CFGHI, 32'h89AB_CDEF);
    busWr(A_EDGE,  32'h0F0F_0000);
    busWr(A_MASK,  32'h0000_F00F);
    busRd(A_CFGLO, rd); check("R4 low cfg readback", rd, 32'h0123_4567);
    busRd(A_CFGHI, rd); check("R4 high cfg readback", rd, 32'h89AB_CDEF);
    busRd(A_EDGE,  rd); check("R6 edge word readback", rd, 32'h0F0F_0000);
    busRd(A_MASK,  rd); check("R9 mask readback", rd, 32'h0000_F00F);

    // ---------------- R3 / R5: exact latency ----------------
    padIn = '0;
    busWr(A_EDGE, '0);
    busWr(A_MASK, '0);
    setCfg(0, 2'b10);
    idle(4);
    busWr(A_STAT, '1);
    busRd(A_STAT, rd); check("R5 quiet before edge", rd, '0);
    padIn[5] = 1'b1;
    idle(1);
    busRd(A_PADS, rd); check("R3 one edge: pad not yet seen", rd, '0);
    busRd(A_STAT, rd); check("R5 one edge: no status", rd, '0);
    idle(1);
    busRd(A_PADS, rd); check("R3 two edges: pad seen", rd, 32'h20);
    busRd(A_STAT, rd); check("R5 two edges: no status yet", rd, '0);
    idle(1);
    busRd(A_STAT, rd); check("R5 three edges: status set", rd, 32'h20);

    // ---------------- R7: selective clear ----------------
    padIn = '0;
    idle(4);
    busWr(A_STAT, '1);
    padIn[3] = 1'b1; padIn[20] = 1'b1;
    idle(4);
    busRd(A_STAT, rd); check("R7 two pending", rd, 32'h0010_0008);
    busWr(A_STAT, 32'h8);
    busRd(A_STAT, rd); check("R7 clear one bit only", rd, 32'h0010_0000);
    busWr(A_STAT, 32'h0);
    busRd(A_STAT, rd); check("R7 write zero keeps bits", rd, 32'h0010_0000);
    busWr(A_STAT, '1);
    busRd(A_STAT, rd); check("R7 clear all", rd, '0);

    // ---------------- sweep: every pin, every trigger kind ----------------
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic idleV;
        logic level;
        logic [NP-1:0] bitP;
        bitP  = NP'(1) << p;
        idleV = (m == 0 || m == 3);       // low level / falling idle high
        level = (m == 0 || m == 1);
        padIn = idleV ? bitP : '0;
        idle(4);
        // any-edge: field set to low-level, which would fire on idle 0 if used
        setCfg(p, (m == 4) ? 2'b00 : 2'(m));
        busWr(A_EDGE, (m == 4) ? DW'(bitP) : '0);
        busWr(A_MASK, DW'(bitP));
        busWr(A_STAT, '1);
        busRd(A_STAT, rd);
        check((m == 4) ? "R6 field ignored, idle quiet" : "R4 idle quiet", rd, '0);
        padIn = idleV ? '0 : bitP;
        idle(4);
        busRd(A_STAT, rd);
        check((m == 4) ? "R6 any-edge first edge" : "R5 trigger sets status", rd, DW'(bitP));
        check("R9 irq halves", {30'd0, irqHigh, irqLow}, (p < 16) ? 32'd1 : 32'd2);
        busWr(A_STAT, DW'(bitP));
        busRd(A_STAT, rd);
        check(level ? "R8 level re-asserts over clear" : "R7 edge status cleared",
              rd, level ? DW'(bitP) : '0);
        if (m == 4) begin
          padIn = '0;
          idle(4);
          busRd(A_STAT, rd);
          check("R6 any-edge second edge", rd, DW'(bitP));
          busWr(A_STAT, DW'(bitP));
        end
        if (level) begin
          busWr(A_MASK, '0);
          check("R9 masked pending gives no irq", {30'd0, irqHigh, irqLow}, '0);
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule